// File: doc/BRIEF.md
# Paged Control Register Bank

The block is a bank of 8-bit control registers spread over numbered pages. A host reaches it through a plain byte-wide port: a 7-bit in-page address, write data with a write strobe, and a read strobe that returns data on `rdata`. A single page pointer decides which page every later access lands on. In-page address 0 is that pointer on every page, including pages that do not exist, so the host can always steer back.

Only a sparse set of page numbers is implemented: 0, 1, 3, 4 to 5, 8 to 15, 32 to 43, 64 to 95 and 252. Each implemented page holds sixteen generic read/write registers at in-page addresses 2 to 17. Any other page number is reserved. While a reserved page is selected, the bank refuses the access and pulses an error flag.

In-page address 1 of page 0 carries a software reset bit. Writing 1 to it starts a one-cycle clear that returns the pointer and all storage to zero.

The control sequence has two named states. RUN is the state after reset and serves accesses. The transition RUN to CLEAR is taken on a software reset write. CLEAR ignores the port and zeroes the bank. The transition CLEAR to RUN always follows after one cycle.

Top module: `paged_ctrl_bank`

## Requirements
- R1: After `rst_n` is released, the page pointer is 0, every register reads 0x00, and `rdata` and `err` are 0.
- R2: `rdata` takes a new value at the clock edge that samples `rd_en` high. It then holds that value until the next read.
- R3: A write to in-page address 0 on any page, valid or reserved, loads the 8-bit page pointer. A read of address 0 on any page returns the pointer. The pointer changes only through such a write or a reset.
- R4: The implemented pages are exactly 0, 1, 3, 4–5, 8–15, 32–43, 64–95 and 252. Every other value of the 8-bit page number is reserved.
- R5: While the pointer selects a reserved page, an access to an address other than 0 does not change storage and a read returns 0x00. `err` is 1 for exactly the one cycle after the edge that sampled the access. `err` is 0 at all other times.
- R6: On an implemented page, addresses 2 to 17 are read/write registers. Each one returns the last byte written to it, and each page has its own set.
- R7: On an implemented page, address 1 (except on page 0) and addresses 18 to 127 ignore writes and read back 0x00.
- R8: A write to page 0 address 1 with bit 0 set moves the bank to CLEAR for the next cycle. Any access in that cycle is ignored. At the end of that cycle the pointer and all registers are 0.
- R9: On page 0, bits 7..1 of address 1 are ignored, and the address always reads 0x00. A write with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | In-page register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered |
| err | output | 1 | One-cycle pulse on an access to a reserved page |

## Verification
Read data and the error pulse are due at the rising edge that samples the strobe. A pointer or register write is visible to a read issued in the following cycle. A software reset clears the bank at the second edge after its write.

The bench changes its inputs on the falling edge. A behavioural model updates on each rising edge, and the bench compares `rdata` and `err` with it on the next falling edge. Every due value is therefore checked in the cycle it becomes visible and in every cycle it must be held.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int PAGE_W  = 8;
    localparam int RANGE_N = 7;

    // implemented page ranges, entry 0 is the rightmost element
    localparam logic [RANGE_N-1:0][PAGE_W-1:0] RANGE_LO =
        {8'd252, 8'd64, 8'd32, 8'd8, 8'd4, 8'd3, 8'd0};
    localparam logic [RANGE_N-1:0][PAGE_W-1:0] RANGE_HI =
        {8'd252, 8'd95, 8'd43, 8'd15, 8'd5, 8'd3, 8'd1};

    function automatic int range_base(input int upto);
        int s;
        s = 0;
        for (int k = 0; k < upto; k++)
            s += int'(RANGE_HI[k]) - int'(RANGE_LO[k]) + 1;
        return s;
    endfunction

    localparam int SLOT_N = range_base(RANGE_N);
    localparam int SLOT_W = $clog2(SLOT_N);

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_CLEAR = 1'b1
    } bank_state_t;
endpackage

// File: rtl/pcb_page_decoder.sv
module pcb_page_decoder
    import pcb_pkg::*;
(
    input  logic [PAGE_W-1:0] page,
    output logic              valid,
    output logic [SLOT_W-1:0] slot
);
    logic [RANGE_N-1:0]             hit;
    logic [RANGE_N-1:0][SLOT_W-1:0] cand;

    for (genvar g = 0; g < RANGE_N; g++) begin : g_rng
        localparam logic [PAGE_W-1:0] LO   = RANGE_LO[g];
        localparam logic [PAGE_W-1:0] SPAN = RANGE_HI[g] - RANGE_LO[g];
        localparam int                BASE = range_base(g);
        logic [PAGE_W-1:0] off;
        assign off     = page - LO;
        assign hit[g]  = (off <= SPAN);
        assign cand[g] = SLOT_W'(BASE) + off[SLOT_W-1:0];
    end

    always_comb begin
        valid = |hit;
        slot  = '0;
        for (int g = 0; g < RANGE_N; g++)
            if (hit[g]) slot = cand[g];
    end
endmodule

// File: rtl/pcb_reg_store.sv
module pcb_reg_store #(
    parameter int DATA_W = 8,
    parameter int SLOT_N = 58,
    parameter int SLOT_W = 6,
    parameter int WIN_N  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    input  logic [SLOT_W-1:0] slot,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rval
);
    localparam int CELL_N = SLOT_N * WIN_N;
    localparam int CELL_W = $clog2(CELL_N);

    logic [DATA_W-1:0] cells [CELL_N];
    logic [CELL_W-1:0] cix;

    assign cix  = CELL_W'(slot) * CELL_W'(WIN_N) + CELL_W'(idx);
    assign rval = cells[cix];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CELL_N; i++) cells[i] <= '0;
        end else if (clear) begin
            for (int i = 0; i < CELL_N; i++) cells[i] <= '0;
        end else if (we) begin
            cells[cix] <= wdata;
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rval == '0)); // R8
endmodule

// File: rtl/paged_ctrl_bank.sv
module paged_ctrl_bank
    import pcb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 7,
    parameter int WIN_BASE = 2,
    parameter int WIN_N    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    localparam int                IDX_W  = $clog2(WIN_N);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] WIN_HX = ADDR_W'(WIN_BASE + WIN_N);
    localparam logic [ADDR_W-1:0] A_PTR  = '0;
    localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(1);

    bank_state_t       state, state_nx;
    logic [PAGE_W-1:0] page_ptr;
    logic              page_ok;
    logic [SLOT_W-1:0] slot;
    logic [ADDR_W-1:0] off;
    logic [IDX_W-1:0]  widx;
    logic              in_win, is_ptr, is_srst, running;
    logic              store_we, srst_req;
    logic [DATA_W-1:0] store_rval, rd_val;

    pcb_page_decoder u_dec (
        .page  (page_ptr),
        .valid (page_ok),
        .slot  (slot)
    );

    assign off      = addr - WIN_LO;
    assign widx     = off[IDX_W-1:0];
    assign in_win   = (addr >= WIN_LO) && (addr < WIN_HX);
    assign is_ptr   = (addr == A_PTR);
    assign is_srst  = (page_ptr == '0) && (addr == A_SRST);
    assign running  = (state == ST_RUN);
    assign store_we = running && wr_en && page_ok && in_win;
    assign srst_req = running && wr_en && page_ok && is_srst && wdata[0];

    pcb_reg_store #(
        .DATA_W (DATA_W),
        .SLOT_N (SLOT_N),
        .SLOT_W (SLOT_W),
        .WIN_N  (WIN_N),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_CLEAR),
        .we    (store_we),
        .slot  (slot),
        .idx   (widx),
        .wdata (wdata),
        .rval  (store_rval)
    );

    always_comb begin
        if (is_ptr)                rd_val = DATA_W'(page_ptr);
        else if (page_ok && in_win) rd_val = store_rval;
        else                       rd_val = '0;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (srst_req) state_nx = ST_CLEAR;
            ST_CLEAR: state_nx = ST_RUN;
            default:  state_nx = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // outputs and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_ptr <= '0;
            rdata    <= '0;
            err      <= 1'b0;
        end else begin
            err <= 1'b0;
            unique case (state)
                ST_CLEAR: page_ptr <= '0;
                ST_RUN: begin
                    if (wr_en && is_ptr) page_ptr <= wdata[PAGE_W-1:0];
                    if (rd_en)           rdata    <= rd_val;
                    err <= (wr_en || rd_en) && !is_ptr && !page_ok;
                end
                default: page_ptr <= '0;
            endcase
        end
    end

    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |=> (state == ST_RUN)); // R8
    AST_CLEAR_ZERO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |=> (page_ptr == '0)); // R8
    AST_PTR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(wr_en && is_ptr)) |=> $stable(page_ptr)); // R3
    AST_ERR_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(!page_ok)); // R5
endmodule

// File: tb/test_paged_ctrl_bank.sv
module test_paged_ctrl_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       err;

    int    total = 0;
    int    bad = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference
    int              m_ptr;
    bit              m_pend;
    byte unsigned    m_mem [int];
    logic [7:0]      m_rdata;
    bit              m_err;

    paged_ctrl_bank i_paged_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .err(err)
    );

    always #10 clk = ~clk;

    function automatic bit page_exists(int p);
        return p inside {[0:1], 3, [4:5], [8:15], [32:43], [64:95], 252};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_pend = 0; m_mem.delete(); m_rdata = 8'h00; m_err = 0;
        end else begin
            m_err = 0;
            if (m_pend) begin
                m_pend = 0; m_ptr = 0; m_mem.delete();
            end else begin
                int  key;
                bit  ok;
                key = m_ptr * 128 + int'(addr);
                ok  = page_exists(m_ptr);
                if (rd_en) begin
                    if (addr == 0)                          m_rdata = 8'(m_ptr);
                    else if (ok && addr >= 2 && addr <= 17)  m_rdata = m_mem.exists(key) ? m_mem[key] : 8'h00;
                    else                                    m_rdata = 8'h00;
                end
                m_err = (wr_en || rd_en) && addr != 0 && !ok;
                if (wr_en) begin
                    if (addr == 0)                          m_ptr = int'(wdata);
                    else if (ok && m_ptr == 0 && addr == 1) m_pend = wdata[0];
                    else if (ok && addr >= 2 && addr <= 17) m_mem[key] = wdata;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            total++;
            if (rdata !== m_rdata) begin
                bad++;
                $display("FAIL %s rdata actual=%h expected=%h", cur_req, rdata, m_rdata);
            end
            total++;
            if (err !== m_err) begin
                bad++;
                $display("FAIL %s err actual=%b expected=%b", cur_req, err, m_err);
            end
        end
    end

    task automatic acc(input bit w, input bit r, input int a, input int d);
        wr_en = w; rd_en = r; addr = 7'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic wr(input int a, input int d); acc(1, 0, a, d); endtask
    task automatic rd(input int a); acc(0, 1, a, 0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        @(negedge clk);

        cur_req = "R1";
        rd(0); rd(2); rd(17); rd(1);

        cur_req = "R6";
        for (int a = 2; a <= 17; a++) wr(a, a * 11 + 3);
        for (int a = 2; a <= 17; a++) rd(a);
        wr(0, 9);
        for (int a = 2; a <= 17; a++) wr(a, 255 - a);
        wr(0, 0);
        for (int a = 2; a <= 17; a++) rd(a);

        cur_req = "R2";
        rd(5); acc(0, 0, 6, 0); acc(0, 0, 0, 0); wr(7, 8'hC3); acc(0, 0, 5, 0); rd(7);

        cur_req = "R3";
        wr(0, 5); rd(0); wr(4, 8'hA5); rd(4);
        wr(0, 4); rd(4); rd(0);
        wr(0, 200); rd(0); wr(0, 8'hFF); rd(0); wr(0, 1); rd(0);

        cur_req = "R4";
        for (int p = 0; p < 256; p++) begin
            wr(0, p); wr(2, p ^ 8'h5A); rd(2);
        end

        cur_req = "R5";
        wr(0, 2); wr(5, 8'h77); rd(5); rd(0); acc(0, 0, 0, 0);
        wr(0, 252); rd(5); wr(0, 253); rd(9); wr(9, 1); acc(0, 0, 0, 0);
        wr(0, 96); rd(2); wr(0, 31); wr(3, 8'h12); rd(3);

        cur_req = "R7";
        wr(0, 1); wr(1, 8'h3C); rd(1); wr(18, 8'h44); rd(18); wr(127, 8'h99); rd(127);
        wr(0, 0); wr(18, 8'h44); rd(18); rd(100);

        cur_req = "R9";
        wr(0, 0); wr(3, 8'h6E); wr(1, 8'hFE); rd(1); rd(3); rd(0);
        wr(0, 12); wr(1, 8'h01); rd(1); wr(0, 0); rd(3);

        cur_req = "R8";
        wr(0, 0); wr(10, 8'h81);
        wr(0, 64); wr(17, 8'h42); wr(0, 0);
        wr(1, 8'h01);
        wr(0, 64);
        rd(0); rd(10);
        wr(0, 64); rd(17); wr(0, 0); rd(0);
        wr(1, 8'hFF); rd(9); rd(0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule